// File: doc/BRIEF.md
# Edge-Triggered Interrupt Status Controller

This block collects the interrupt requests of a small 8-bit processor core. There are four sources: two external pins, a 16-bit timer rollover, and a summary of the peripheral interrupts. Each pin input passes through a two-flop synchronizer. An edge detector then responds to one direction only, and a per-pin select input chooses that direction. Pin edges and timer rollovers set sticky flag bits. The peripheral summary is not stored; it is computed every cycle from a peripheral flag vector ANDed with a peripheral enable vector.

The four enables, three sticky flags and the peripheral summary share one 8-bit status register on a simple bus port. Software reads this register and clears flags by writing zeros to them. The block drives an interrupt request that is gated by a global disable input. It also drives a wake signal that responds to enabled pin flags even while interrupts are globally disabled.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, bits 6 to 0 of the status register read 0, and irq_o and wake_o are low.
- R2: When pin_a_rise_i is 1, a low-to-high change on pin_a_i sets status bit 4 within three clock edges, and a high-to-low change leaves bit 4 unchanged.
- R3: When pin_a_rise_i is 0, a high-to-low change on pin_a_i sets status bit 4, and a low-to-high change leaves bit 4 unchanged.
- R4: Pin B behaves the same way, with its direction chosen by pin_b_rise_i and its flag at status bit 6. Pin B edges do not touch bit 4.
- R5: A one-cycle pulse on tmr_wrap_i sets status bit 5 on the next clock edge.
- R6: Status bit 7 reads as the OR over all bit positions of periph_flag_i AND periph_en_i. Writes to bit 7 have no effect.
- R7: The flags in bits 4 to 6 are sticky. A write of 0 to a flag bit clears it, and a write of 1 leaves it unchanged. Bits 3 to 0 (pin A, timer, pin B, peripheral enables) take the written value.
- R8: If a flag's event and a write clearing that flag happen in the same cycle, the flag ends up set.
- R9: irq_o is high exactly when some flag is set together with its enable and glb_dis_i is low. While glb_dis_i is high, events still set their flags.
- R10: wake_o is high when pin A's flag and enable are both set, or pin B's flag and enable are both set, regardless of glb_dis_i. Timer and peripheral flags do not drive wake_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_a_i | input | 1 | External pin A, asynchronous |
| pin_b_i | input | 1 | External pin B, asynchronous |
| pin_a_rise_i | input | 1 | Pin A direction: 1 = rising edge, 0 = falling edge |
| pin_b_rise_i | input | 1 | Pin B direction: 1 = rising edge, 0 = falling edge |
| tmr_wrap_i | input | 1 | One-cycle pulse when the 16-bit timer wraps from FFFFh to 0000h |
| periph_flag_i | input | NUM_PERIPH | Peripheral flag vector |
| periph_en_i | input | NUM_PERIPH | Peripheral enable vector |
| glb_dis_i | input | 1 | Global interrupt disable |
| stat_wr_i | input | 1 | Write strobe for the status register |
| stat_wdata_i | input | 8 | Status write data |
| stat_rdata_o | output | 8 | Status read data |
| irq_o | output | 1 | Interrupt request to the core |
| wake_o | output | 1 | Wake-from-sleep request |

## Verification
The assertions assume three things about the inputs.
- tmr_wrap_i is a single-cycle pulse.
- A pin's direction select is not changed in the cycle right after that pin's detector fires.
- The pins are quiet and low while reset is held.

The stimulus changes each direction select only while its pin is steady. It drives every input on the falling clock edge, and it returns the pins low before any reset.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

  localparam int STAT_W = 8;
  localparam int NUM_FLAGS = 3;   // pin A, timer, pin B
  localparam int NUM_EN = 4;

  // status bit positions; enables at i, sticky flags at FLAG_BASE + i
  localparam int B_EN_A  = 0;
  localparam int B_EN_T  = 1;
  localparam int B_EN_B  = 2;
  localparam int B_EN_P  = 3;
  localparam int FLAG_BASE = 4;
  localparam int B_FL_A  = 4;
  localparam int B_FL_T  = 5;
  localparam int B_FL_B  = 6;
  localparam int B_FL_P  = 7;

  typedef enum logic [1:0] {
    SRC_PIN_A  = 2'd0,
    SRC_TMR    = 2'd1,
    SRC_PIN_B  = 2'd2,
    SRC_PERIPH = 2'd3
  } irq_src_e;

  typedef struct packed {
    logic pflag;
    logic fl_b;
    logic fl_t;
    logic fl_a;
    logic en_p;
    logic en_b;
    logic en_t;
    logic en_a;
  } stat_t;

  // edge of the selected direction between two successive samples
  function automatic logic edge_hit(logic prev, logic cur, logic rise_sel);
    return (prev != cur) && (cur == rise_sel);
  endfunction

  // sticky flag update: an event dominates a clearing write
  function automatic logic flag_next(logic cur, logic evt, logic wr, logic wbit);
    return evt | (cur & ~(wr & ~wbit));
  endfunction

endpackage

// File: rtl/pin_edge_det.sv
module pin_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic edge_o
);
  import irq_stat_pkg::*;

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   synced;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  assign synced = sync_q[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= synced;
  end

  assign edge_o = edge_hit(prev_q, synced, rise_sel_i);

  // two detections in a row would need two changes in the same direction
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(edge_o) && $stable(rise_sel_i)) |-> !edge_o); // R2

endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  import irq_stat_pkg::*;

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_next(flag_q, evt_i, wr_i, wbit_i);
  end

  assign flag_o = flag_q;

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> flag_o); // R8

  AST_SET_ONLY_BY_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(flag_o) && !$past(evt_i)) |-> !flag_o); // R7

  AST_HOLD_WITHOUT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !wr_i) |=> flag_o); // R7

endmodule

// File: rtl/periph_reduce.sv
module periph_reduce #(
  parameter int NUM_PERIPH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PERIPH-1:0] flag_i,
  input  logic [NUM_PERIPH-1:0] en_i,
  output logic                  any_o
);

  logic [NUM_PERIPH-1:0] hit;

  generate
    for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_hit
      assign hit[p] = flag_i[p] & en_i[p];
    end
  endgenerate

  always_comb begin
    any_o = 1'b0;
    for (int p = 0; p < NUM_PERIPH; p++) any_o = any_o | hit[p];
  end

  AST_PFLAG_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> (en_i != '0) && (flag_i != '0)); // R6

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int NUM_PERIPH  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pin_a_i,
  input  logic                  pin_b_i,
  input  logic                  pin_a_rise_i,
  input  logic                  pin_b_rise_i,
  input  logic                  tmr_wrap_i,
  input  logic [NUM_PERIPH-1:0] periph_flag_i,
  input  logic [NUM_PERIPH-1:0] periph_en_i,
  input  logic                  glb_dis_i,
  input  logic                  stat_wr_i,
  input  logic [7:0]            stat_wdata_i,
  output logic [7:0]            stat_rdata_o,
  output logic                  irq_o,
  output logic                  wake_o
);
  import irq_stat_pkg::*;

  logic [1:0]           pin_in;
  logic [1:0]           pin_sel;
  logic [1:0]           pin_edge;      // [0] pin A, [1] pin B
  logic [NUM_FLAGS-1:0] flag_evt;
  logic [NUM_FLAGS-1:0] flag_vec;
  logic [NUM_EN-1:0]    en_q;
  logic                 periph_any;
  logic [NUM_EN-1:0]    pend_vec;
  stat_t                stat;
  logic                 unused_wbit;

  assign pin_in  = {pin_b_i, pin_a_i};
  assign pin_sel = {pin_b_rise_i, pin_a_rise_i};

  generate
    for (genvar k = 0; k < 2; k++) begin : g_pin
      pin_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pin_in[k]),
        .rise_sel_i (pin_sel[k]),
        .edge_o     (pin_edge[k])
      );
    end
  endgenerate

  assign flag_evt[SRC_PIN_A] = pin_edge[0];
  assign flag_evt[SRC_TMR]   = tmr_wrap_i;
  assign flag_evt[SRC_PIN_B] = pin_edge[1];

  generate
    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
      sticky_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (flag_evt[f]),
        .wr_i   (stat_wr_i),
        .wbit_i (stat_wdata_i[FLAG_BASE + f]),
        .flag_o (flag_vec[f])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         en_q <= '0;
    else if (stat_wr_i) en_q <= stat_wdata_i[NUM_EN-1:0];
  end

  assign unused_wbit = stat_wdata_i[B_FL_P];

  periph_reduce #(.NUM_PERIPH(NUM_PERIPH)) u_periph (
    .clk    (clk),
    .rst_n  (rst_n),
    .flag_i (periph_flag_i),
    .en_i   (periph_en_i),
    .any_o  (periph_any)
  );

  always_comb begin
    stat.en_a  = en_q[B_EN_A];
    stat.en_t  = en_q[B_EN_T];
    stat.en_b  = en_q[B_EN_B];
    stat.en_p  = en_q[B_EN_P];
    stat.fl_a  = flag_vec[SRC_PIN_A];
    stat.fl_t  = flag_vec[SRC_TMR];
    stat.fl_b  = flag_vec[SRC_PIN_B];
    stat.pflag = periph_any;
  end

  assign stat_rdata_o = stat;

  assign pend_vec = {stat.pflag & stat.en_p, stat.fl_b & stat.en_b,
                     stat.fl_t & stat.en_t, stat.fl_a & stat.en_a};

  assign irq_o  = ~glb_dis_i & (|pend_vec);
  assign wake_o = pend_vec[SRC_PIN_A] | pend_vec[SRC_PIN_B];

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (stat_rdata_o[6:0] == 7'd0)); // R1

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (stat_rdata_o[7:4] != 4'd0) && !glb_dis_i); // R9

  AST_WAKE_FROM_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (stat_rdata_o[B_FL_A] | stat_rdata_o[B_FL_B])); // R10

  AST_TIMER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wrap_i |=> stat_rdata_o[B_FL_T]); // R5

  AST_PIN_B_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    pin_edge[1] |=> stat_rdata_o[B_FL_B]); // R4

endmodule

// File: tb/sim_irq_status_ctrl.sv
`timescale 1ns/1ps
module sim_irq_status_ctrl;

  localparam int NP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_a = 1'b0, pin_b = 1'b0, sel_a = 1'b0, sel_b = 1'b0;
  logic tmr_wrap = 1'b0, glb_dis = 1'b0, wr = 1'b0;
  logic [NP-1:0] pflag = '0, pen = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq, wake;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_status_ctrl #(.NUM_PERIPH(NP), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_a_i(pin_a), .pin_b_i(pin_b),
    .pin_a_rise_i(sel_a), .pin_b_rise_i(sel_b), .tmr_wrap_i(tmr_wrap),
    .periph_flag_i(pflag), .periph_en_i(pen), .glb_dis_i(glb_dis),
    .stat_wr_i(wr), .stat_wdata_i(wdata), .stat_rdata_o(rdata),
    .irq_o(irq), .wake_o(wake)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_stat(input logic [7:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic drive_pin(input bit which_b, input logic v);
    @(negedge clk);
    if (which_b) pin_b = v; else pin_a = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_tmr();
    @(negedge clk); tmr_wrap = 1'b1;
    @(negedge clk); tmr_wrap = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 status", rdata, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 wake", {7'd0, wake}, 8'h00);
  endtask

  task automatic t_pin_a_rise();
    sel_a = 1'b1;
    drive_pin(1'b0, 1'b1);
    chk("R2 rise sets bit4", rdata, 8'h10);
    wr_stat(8'h00);
    chk("R7 clear bit4", rdata, 8'h00);
    drive_pin(1'b0, 1'b0);
    chk("R2 fall ignored", rdata, 8'h00);
  endtask

  task automatic t_pin_a_fall();
    @(negedge clk); sel_a = 1'b0;
    drive_pin(1'b0, 1'b1);
    chk("R3 rise ignored", rdata, 8'h00);
    drive_pin(1'b0, 1'b0);
    chk("R3 fall sets bit4", rdata, 8'h10);
    wr_stat(8'h00);
  endtask

  task automatic t_pin_b();
    @(negedge clk); sel_b = 1'b1;
    drive_pin(1'b1, 1'b1);
    chk("R4 rise sets bit6 only", rdata, 8'h40);
    wr_stat(8'h00);
    @(negedge clk); sel_b = 1'b0;
    drive_pin(1'b1, 1'b0);
    chk("R4 fall sets bit6", rdata, 8'h40);
    wr_stat(8'h00);
    chk("R4 cleared", rdata, 8'h00);
  endtask

  task automatic t_timer();
    pulse_tmr();
    chk("R5 wrap sets bit5", rdata, 8'h20);
    wr_stat(8'h70);
    chk("R7 write one keeps flag", rdata, 8'h20);
    wr_stat(8'h05);
    chk("R7 write zero clears, enables load", rdata, 8'h05);
    wr_stat(8'h70);
    chk("R7 write one does not set", rdata, 8'h00);
  endtask

  task automatic t_race();
    pulse_tmr();
    @(negedge clk); tmr_wrap = 1'b1; wr = 1'b1; wdata = 8'h00;
    @(negedge clk); tmr_wrap = 1'b0; wr = 1'b0;
    chk("R8 event beats clear", rdata, 8'h20);
    wr_stat(8'h00);
  endtask

  task automatic t_periph();
    @(negedge clk); pflag = 8'h05; pen = 8'h02;
    @(negedge clk);
    chk("R6 disjoint masks", rdata, 8'h00);
    pen = 8'h84;
    @(negedge clk);
    chk("R6 overlap sets bit7", rdata, 8'h80);
    wr_stat(8'h00);
    chk("R6 write 0 to bit7 ignored", rdata, 8'h80);
    @(negedge clk); pen = 8'h00;
    wr_stat(8'h80);
    chk("R6 write 1 to bit7 ignored", rdata, 8'h00);
  endtask

  task automatic t_irq();
    wr_stat(8'h02);
    pulse_tmr();
    chk("R9 irq from timer", {7'd0, irq}, 8'h01);
    @(negedge clk); glb_dis = 1'b1;
    @(negedge clk);
    chk("R9 irq masked", {7'd0, irq}, 8'h00);
    wr_stat(8'h02);
    pulse_tmr();
    chk("R9 flag set while disabled", rdata, 8'h22);
    chk("R9 irq still masked", {7'd0, irq}, 8'h00);
    @(negedge clk); glb_dis = 1'b0;
    @(negedge clk);
    chk("R9 irq after release", {7'd0, irq}, 8'h01);
    wr_stat(8'h00);
    chk("R9 no enabled flag", {7'd0, irq}, 8'h00);
    @(negedge clk); pflag = 8'h01; pen = 8'h01;
    wr_stat(8'h08);
    chk("R9 irq from peripheral", {7'd0, irq}, 8'h01);
    chk("R10 peripheral no wake", {7'd0, wake}, 8'h00);
    @(negedge clk); pflag = '0; pen = '0;
    wr_stat(8'h00);
  endtask

  task automatic t_wake();
    wr_stat(8'h03);
    @(negedge clk); glb_dis = 1'b1; sel_a = 1'b1;
    drive_pin(1'b0, 1'b1);
    chk("R10 wake with disable", {6'd0, wake, irq}, 8'h02);
    wr_stat(8'h02);
    pulse_tmr();
    chk("R10 timer no wake", {7'd0, wake}, 8'h00);
    @(negedge clk); glb_dis = 1'b0;
    wr_stat(8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pin_a_rise();
    t_pin_a_fall();
    t_pin_b();
    t_timer();
    t_race();
    t_periph();
    t_irq();
    t_wake();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule